// File: doc/BRIEF.md
# Self-Routing Omega Request Router

This block steers up to eight simultaneous requests from processor-side ports to eight memory-side ports. It uses a three-stage network of 2x2 interchange switches. Each input port presents a valid flag, a 3-bit destination port number and a data word. A perfect-shuffle wiring feeds every stage. Each switch picks its upper or lower output from one bit of the destination, starting with the most significant bit. Exactly one route exists from any input to any output. When two requests in the same switch want the same output, the one on the switch's upper input wins. The other request is dropped for the rest of the network.

For each input, the router raises either a grant or a blocked flag combinationally, in the same cycle as the request. The network outputs are registered. Each output port shows a valid bit, the data word and the number of the source that reached it, one clock edge after the request was presented. Blocked requests are not queued or retried. Deciding whether to present them again is the requester's job.

Top module: `omega_router`

## Requirements
- R1: During and after a synchronous active-low reset, `out_valid` is all zero, and `out_data` and `out_src` are zero on every port, until the first request is registered.
- R2: A request presented alone on any input i with destination d always succeeds. On the first rising edge after it is presented, output port d shows `out_valid` 1, the request's data word and `out_src` equal to i.
- R3: A permutation in which every input i targets destination (i + c) mod 8, for any constant c, passes with all eight requests granted and each delivered to its own destination.
- R4: Inside a switch, a request on the upper input (the even shuffled line) always wins a conflict over the lower input (the odd line). Stage k, counting from 0, steers on destination bit 2-k: a bit value 0 takes the upper output and 1 takes the lower output. The line feeding each stage is the 3-bit index rotated left by one position.
- R5: `grant[i]` is 1 only when input i is valid and its request reaches an output. `blocked[i]` is 1 exactly when input i is valid and not granted. An idle input shows neither flag. Both flags follow the inputs in the same cycle, with no clock edge in between.
- R6: Input 0 targeting destination 0 together with input 4 targeting destination 1 cannot both be connected: input 0 is granted and input 4 is blocked.
- R7: When several requests target one destination, exactly one of them is granted. No output ever carries two requests, and the number of valid outputs equals the number of grants of the previous cycle.
- R8: A blocked request's data appears on no output. An output port that no request reached shows `out_valid` 0 with `out_data` and `out_src` zero.
- R9: The outputs change only at a rising clock edge. A change of the inputs between edges leaves `out_valid`, `out_data` and `out_src` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 8 | Request present, one bit per input port |
| in_dst | input | 24 | Destination port number, 3 bits per input, input i at bits [3i+2:3i] |
| in_data | input | 64 | Data word, 8 bits per input, input i at bits [8i+7:8i] |
| grant | output | 8 | Request of that input reached an output this cycle |
| blocked | output | 8 | Request of that input lost a switch conflict this cycle |
| out_valid | output | 8 | Output port carries a delivered request, registered |
| out_data | output | 64 | Delivered data word, 8 bits per output port, registered |
| out_src | output | 24 | Number of the source that reached that output, 3 bits per port, registered |

## Verification
Grant and blocked are combinational, so the bench checks them 1 ns after driving the inputs on a falling edge, before any rising edge can intervene. The output ports pass through one register. Their expected values are checked 1 ns after the next rising edge. R9 is checked by changing the inputs on a falling edge and confirming that the outputs still hold the previous values at that moment. Expected grants and deliveries come from a separate stage-by-stage position model in the bench. This model is applied to single requests across all 64 source and destination pairs, to shifted permutations, to the forced collisions and to a run of pseudo-random patterns.

// File: rtl/omega_pkg.sv
// Package omega_pkg
// Shared helpers for the omega router: lane width and the perfect-shuffle
// index mapping. Assumes port counts are powers of two.
package omega_pkg;

    // Width of one lane: valid, source number, destination, data.
    function automatic int lane_width(input int addr_w, input int data_w);
        return 1 + 2 * addr_w + data_w;
    endfunction

    // Perfect shuffle: rotate an addr_w-bit line index left by one position.
    function automatic int shuffle_idx(input int idx, input int addr_w);
        int mask;
        mask = (1 << addr_w) - 1;
        return ((idx << 1) | (idx >> (addr_w - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch2x2.sv
// Module omega_switch2x2
// One 2x2 interchange element. Each input lane carries {valid, src, dst, data}.
// The destination bit SEL_BIT picks the output: 0 selects up, 1 selects dn.
// When both inputs want the same output, input A wins and B is dropped.
// An output that nobody claims carries an all-zero lane.
module omega_switch2x2 #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SEL_BIT = 2,
    localparam int LANE_W = omega_pkg::lane_width(ADDR_W, DATA_W)
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    output logic [LANE_W-1:0] up_lane,
    output logic [LANE_W-1:0] dn_lane
);
    localparam int V_POS   = LANE_W - 1;
    localparam int SEL_POS = DATA_W + SEL_BIT;

    logic a_v, b_v, a_sel, b_sel;

    // Extract request flags and steering bits.
    always_comb begin
        a_v   = a_lane[V_POS];
        b_v   = b_lane[V_POS];
        a_sel = a_lane[SEL_POS];
        b_sel = b_lane[SEL_POS];
    end

    // Upper output: A has priority, B only if A does not claim it.
    always_comb begin
        if (a_v && !a_sel)      up_lane = a_lane;
        else if (b_v && !b_sel) up_lane = b_lane;
        else                    up_lane = '0;
    end

    // Lower output: same priority rule.
    always_comb begin
        if (a_v && a_sel)       dn_lane = a_lane;
        else if (b_v && b_sel)  dn_lane = b_lane;
        else                    dn_lane = '0;
    end
endmodule

// File: rtl/omega_stage.sv
// Module omega_stage
// One network stage: perfect-shuffle wiring followed by a column of N/2
// switches steering on destination bit (ADDR_W-1-STAGE).
// Assumes the lane layout {valid, src, dst, data}. The clock and reset are
// used only by the assertions that guard the switch column.
module omega_stage #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int STAGE   = 0,
    localparam int N      = 1 << ADDR_W,
    localparam int LANE_W = omega_pkg::lane_width(ADDR_W, DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lanes_in  [N],
    output logic [LANE_W-1:0] lanes_out [N]
);
    localparam int SEL_BIT = ADDR_W - 1 - STAGE;
    localparam int V_POS   = LANE_W - 1;
    localparam int SRC_LSB = DATA_W + ADDR_W;
    localparam int SEL_POS = DATA_W + SEL_BIT;

    logic [LANE_W-1:0] shuf [N];

    // Perfect-shuffle wiring into the switch column.
    for (genvar i = 0; i < N; i++) begin : g_shuf
        assign shuf[omega_pkg::shuffle_idx(i, ADDR_W)] = lanes_in[i];
    end

    for (genvar j = 0; j < N / 2; j++) begin : g_sw
        omega_switch2x2 #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SEL_BIT(SEL_BIT)
        ) u_sw (
            .a_lane (shuf[2*j]),
            .b_lane (shuf[2*j+1]),
            .up_lane(lanes_out[2*j]),
            .dn_lane(lanes_out[2*j+1])
        );

        // A valid request on the upper input always leaves on its chosen side.
        AST_A_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
            shuf[2*j][V_POS] |->
            (shuf[2*j][SEL_POS] ? (lanes_out[2*j+1] == shuf[2*j])
                                : (lanes_out[2*j] == shuf[2*j]))); // R4

        // The lower input is dropped only when the upper input took its port.
        AST_B_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (shuf[2*j+1][V_POS] &&
             (lanes_out[2*j] != shuf[2*j+1]) && (lanes_out[2*j+1] != shuf[2*j+1]))
            |-> (shuf[2*j][V_POS] && (shuf[2*j][SEL_POS] == shuf[2*j+1][SEL_POS]))); // R4

        // Both outputs never carry the same request.
        AST_NO_DUP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            (lanes_out[2*j][V_POS] && lanes_out[2*j+1][V_POS]) |->
            (lanes_out[2*j][SRC_LSB +: ADDR_W] != lanes_out[2*j+1][SRC_LSB +: ADDR_W])); // R7
    end
endmodule

// File: rtl/omega_router.sv
// Module omega_router
// Omega network of ADDR_W stages with destination-tag self-routing.
// The grant and blocked flags are combinational from the request inputs.
// Output valid, data and source are registered once per clock.
// Assumes the requesters hold their inputs stable around the rising edge.
module omega_router #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    localparam int N      = 1 << ADDR_W,
    localparam int LANE_W = omega_pkg::lane_width(ADDR_W, DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        in_valid,
    input  logic [N*ADDR_W-1:0] in_dst,
    input  logic [N*DATA_W-1:0] in_data,
    output logic [N-1:0]        grant,
    output logic [N-1:0]        blocked,
    output logic [N-1:0]        out_valid,
    output logic [N*DATA_W-1:0] out_data,
    output logic [N*ADDR_W-1:0] out_src
);
    localparam int V_POS   = LANE_W - 1;
    localparam int SRC_LSB = DATA_W + ADDR_W;
    localparam int DST_LSB = DATA_W;

    logic [LANE_W-1:0] lanes [ADDR_W+1][N];
    logic [N-1:0]      gnt;
    logic              started;

    // Pack each input request into a lane tagged with its source number.
    for (genvar i = 0; i < N; i++) begin : g_pack
        assign lanes[0][i] = {in_valid[i], ADDR_W'(i),
                              in_dst[i*ADDR_W +: ADDR_W], in_data[i*DATA_W +: DATA_W]};
    end

    // Chain the stages; stage k steers on destination bit ADDR_W-1-k.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
        omega_stage #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W),
            .STAGE (k)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .lanes_in (lanes[k]),
            .lanes_out(lanes[k+1])
        );
    end

    // A source is granted when its tag survives on some final lane.
    always_comb begin
        gnt = '0;
        for (int s = 0; s < N; s++) begin
            for (int o = 0; o < N; o++) begin
                if (lanes[ADDR_W][o][V_POS] &&
                    lanes[ADDR_W][o][SRC_LSB +: ADDR_W] == ADDR_W'(s))
                    gnt[s] = 1'b1;
            end
        end
    end

    // Per-input status flags.
    always_comb begin
        grant   = gnt;
        blocked = in_valid & ~gnt;
    end

    // Register the network outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            out_src   <= '0;
        end else begin
            for (int o = 0; o < N; o++) begin
                out_valid[o]                   <= lanes[ADDR_W][o][V_POS];
                out_data[o*DATA_W +: DATA_W]   <= lanes[ADDR_W][o][0 +: DATA_W];
                out_src[o*ADDR_W +: ADDR_W]    <= lanes[ADDR_W][o][SRC_LSB +: ADDR_W];
            end
        end
    end

    // Marks that at least one non-reset edge has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // A granted source must have a live request.
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~in_valid) == '0); // R5

    for (genvar o = 0; o < N; o++) begin : g_chk
        // Every surviving lane lands on the port its destination names.
        AST_LANDS_ON_DST: assert property (@(posedge clk) disable iff (!rst_n)
            lanes[ADDR_W][o][V_POS] |->
            (lanes[ADDR_W][o][DST_LSB +: ADDR_W] == ADDR_W'(o))); // R2
    end

    // Valid outputs count equals the grants of the previous cycle.
    AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> ($countones(out_valid) == $past($countones(grant)))); // R7

    // An output can only be valid if some request was present one edge before.
    AST_OUT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (started && out_valid != '0) |-> $past(in_valid != '0)); // R9
endmodule

// File: tb/omega_router_test.sv
module omega_router_test;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int N  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*AW-1:0] in_dst = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    grant, blocked, out_valid;
    logic [N*DW-1:0] out_data;
    logic [N*AW-1:0] out_src;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state.
    logic [N-1:0] rv;
    int           rd [N];
    logic [7:0]   rdat [N];
    logic [N-1:0] e_gnt;
    logic [N-1:0] e_ov;
    int           e_src [N];

    omega_router #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
        .in_data(in_data), .grant(grant), .blocked(blocked),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model: track each live request's line position stage by stage.
    task automatic model();
        int  pos [N];
        int  pin [N];
        logic [N-1:0] alive;
        alive = rv;
        for (int s = 0; s < N; s++) pos[s] = s;
        for (int k = 0; k < AW; k++) begin
            for (int s = 0; s < N; s++) begin
                pin[s] = ((pos[s] << 1) | (pos[s] >> 2)) & 7;
                pos[s] = (pin[s] & 6) | ((rd[s] >> (2 - k)) & 1);
            end
            for (int s = 0; s < N; s++)
                for (int t = 0; t < N; t++)
                    if (s != t && alive[s] && alive[t] && pos[s] == pos[t] && pin[s][0])
                        alive[s] = 1'b0;
        end
        e_gnt = alive;
        e_ov  = '0;
        for (int o = 0; o < N; o++) e_src[o] = 0;
        for (int s = 0; s < N; s++)
            if (alive[s]) begin
                e_ov[rd[s]]  = 1'b1;
                e_src[rd[s]] = s;
            end
    endtask

    task automatic drive();
        for (int s = 0; s < N; s++) begin
            in_valid[s]          = rv[s];
            in_dst[s*AW +: AW]   = AW'(rd[s]);
            in_data[s*DW +: DW]  = rdat[s];
        end
    endtask

    // Apply the request set at a falling edge, check flags, then outputs.
    task automatic apply_and_check(input string tag);
        @(negedge clk);
        drive();
        model();
        #1;
        check(grant === e_gnt, {tag, " R5 grant"}, grant, e_gnt);
        check(blocked === (rv & ~e_gnt), {tag, " R5 blocked"}, blocked, rv & ~e_gnt);
        @(posedge clk);
        #1;
        check(out_valid === e_ov, {tag, " R7 out_valid"}, out_valid, e_ov);
        for (int o = 0; o < N; o++) begin
            logic [7:0] xd;
            logic [2:0] xs;
            xd = e_ov[o] ? rdat[e_src[o]] : 8'h00;
            xs = e_ov[o] ? 3'(e_src[o]) : 3'd0;
            check(out_data[o*DW +: DW] === xd, {tag, " R8 out_data"}, out_data[o*DW +: DW], xd);
            check(out_src[o*AW +: AW] === xs, {tag, " R2 out_src"}, out_src[o*AW +: AW], xs);
        end
    endtask

    task automatic clear_req();
        rv = '0;
        for (int s = 0; s < N; s++) begin rd[s] = 0; rdat[s] = 8'(8'h30 + s * 17); end
    endtask

    task automatic t_reset();
        clear_req();
        drive();
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === '0, "R1 out_valid in reset", out_valid, 0);
        check(out_data === '0, "R1 out_data in reset", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(out_valid === '0 && out_src === '0, "R1 after reset", out_valid, 0);
        check(grant === '0 && blocked === '0, "R5 idle flags", {grant, blocked}, 0);
    endtask

    task automatic t_single();
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++) begin
                clear_req();
                rv[s] = 1'b1; rd[s] = d; rdat[s] = 8'(s * 8 + d + 1);
                apply_and_check("R2 single");
                check(grant === (8'b1 << s), "R2 lone grant", grant, 8'b1 << s);
            end
    endtask

    task automatic t_shift();
        for (int c = 0; c < N; c++) begin
            clear_req();
            rv = '1;
            for (int s = 0; s < N; s++) rd[s] = (s + c) % N;
            apply_and_check("R3 shift");
            check(out_valid === 8'hFF, "R3 all delivered", out_valid, 8'hFF);
        end
    endtask

    task automatic t_pair_conflict();
        clear_req();
        rv[0] = 1'b1; rd[0] = 0;
        rv[4] = 1'b1; rd[4] = 1;
        apply_and_check("R6 pair");
        check(grant === 8'h01 && blocked === 8'h10, "R6 A wins over B", {grant, blocked}, 16'h0110);
        check(out_valid === 8'h01, "R8 loser not delivered", out_valid, 8'h01);
    endtask

    task automatic t_hot_spot();
        clear_req();
        rv = '1;
        for (int s = 0; s < N; s++) rd[s] = 7;
        apply_and_check("R7 hotspot");
        check($countones(grant) == 1, "R7 one winner", grant, 0);
        check(out_valid === 8'h80, "R7 one output", out_valid, 8'h80);
    endtask

    task automatic t_random();
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            clear_req();
            for (int s = 0; s < N; s++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                rv[s]   = lf[0] | lf[5];
                rd[s]   = int'(lf[4:2]);
                rdat[s] = lf[15:8];
            end
            apply_and_check("R4 random");
        end
    endtask

    task automatic t_hold();
        logic [N-1:0]    v0;
        logic [N*DW-1:0] d0;
        logic [N*AW-1:0] s0;
        clear_req();
        rv = '1;
        for (int s = 0; s < N; s++) rd[s] = (s + 5) % N;
        apply_and_check("R9 setup");
        v0 = out_valid; d0 = out_data; s0 = out_src;
        @(negedge clk);
        clear_req();
        rv[2] = 1'b1; rd[2] = 6;
        drive();
        #2;
        check(out_valid === v0 && out_data === d0 && out_src === s0,
              "R9 outputs hold between edges", out_valid, v0);
        @(posedge clk);
        #1;
        check(out_valid === 8'h40, "R9 update at edge", out_valid, 8'h40);
    endtask

    initial begin
        t_reset();
        t_single();
        t_shift();
        t_pair_conflict();
        t_hot_spot();
        t_random();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule